// File: doc/BRIEF.md
# Infrared Carrier Transmit Modulator

This block produces the waveform that drives an infrared emitter. An internal generator makes a carrier from two programmable counts, one for the high time and one for the low time, each measured in cycles of the base IR clock. A data bit gates the carrier onto the transmit pin. A polarity bit sets the level the pin rests at and inverts the carrier. A second pin can carry the envelope on its own, which is the data bit after the polarity inversion. An external driver can then combine the envelope with either the gated carrier or a free-running carrier.

A programmable down counter times each mark or space. It steps either on every IR clock, for fine resolution, or once per carrier period. When it runs out, the block gives a one-cycle done pulse, reloads the interval and takes in the next data bit. Software or a sequencer uses the pulse to present the following bit and its length. All outputs are registered. When the enable is cleared, every counter restarts and both pins go back to rest.

Top module: `ir_tx_modulator`

## Requirements
- R1: While `rst` is high (synchronous, active high), `tx_out`, `env_out` and `interval_done` are 0 on the following clock edge.
- R2: While `enable` is 0, `tx_out` equals `tx_pol` one cycle later, `env_out` is 0, `interval_done` is 0, and the carrier and interval counters restart from their initial state.
- R3: Once enabled, the carrier begins high. It stays high for `car_high`+1 IR clocks and low for `car_low`+1 IR clocks, and repeats.
- R4: In envelope modes 2'b00, 2'b01 and 2'b11, `tx_out` is the carrier XOR `tx_pol` while the latched data bit is 1, and it is `tx_pol` while the latched data bit is 0.
- R5: In envelope mode 2'b10, `tx_out` is the carrier XOR `tx_pol`, whatever the data bit.
- R6: In envelope modes 2'b00 and 2'b11, `env_out` stays 0.
- R7: In envelope modes 2'b01 and 2'b10, `env_out` is the latched data bit XOR `tx_pol`.
- R8: With `fast_step` = 1, the interval counter steps on every enabled clock, so an interval lasts `interval_len`+1 clocks.
- R9: With `fast_step` = 0, the interval counter steps once per carrier period, on the last cycle of the low phase, so an interval lasts `interval_len`+1 carrier periods.
- R10: On the first enabled cycle, and again on each step that finds the counter at zero, the block loads `interval_len` and latches `tx_data`. A step at zero also raises `interval_done` for exactly one cycle after it.
- R11: `tx_out` and `env_out` are registered. They reflect the carrier and latched data one clock after those internal states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | IR base clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the modulator when 1 |
| tx_pol | input | 1 | Rest level and carrier inversion |
| tx_data | input | 1 | Next mark (1) or space (0), latched at interval boundaries |
| env_mode | input | 2 | Envelope pin and carrier routing mode |
| fast_step | input | 1 | 1: interval steps per IR clock; 0: per carrier period |
| car_high | input | CNT_W | Carrier high time minus one, in IR clocks |
| car_low | input | CNT_W | Carrier low time minus one, in IR clocks |
| interval_len | input | IVL_W | Interval reload value minus one, in steps |
| tx_out | output | 1 | Modulated transmit pin |
| env_out | output | 1 | Envelope pin |
| interval_done | output | 1 | One-cycle pulse at each interval end |

## Verification
The bench builds the block with CNT_W = 4 and IVL_W = 6. Carrier phases of one to four clocks and intervals of up to eight steps therefore roll over many times in a short run. Zero high and low counts, zero reloads and done pulses on back-to-back clocks all occur often. Every envelope mode, both polarities and both step sources are crossed with data changes inside an interval and with the enable dropping part way through.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic [1:0] {
    ENV_OFF_A  = 2'b00,
    ENV_GATED  = 2'b01,
    ENV_FREE   = 2'b10,
    ENV_OFF_B  = 2'b11
  } env_mode_e;

  function automatic logic env_pin_on(input logic [1:0] m);
    return (m == ENV_GATED) || (m == ENV_FREE);
  endfunction

  function automatic logic carrier_free(input logic [1:0] m);
    return (m == ENV_FREE);
  endfunction
endpackage

// File: rtl/irtx_carrier_gen.sv
module irtx_carrier_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] low_len,
  output logic             carrier,
  output logic             period_tick
);
  logic [CNT_W-1:0] phase_cnt;
  logic             level;
  logic             high_end;
  logic             low_end;

  assign high_end    = (phase_cnt >= high_len);
  assign low_end     = (phase_cnt >= low_len);
  assign period_tick = run && !level && low_end;
  assign carrier     = level;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      level     <= 1'b1;
      phase_cnt <= '0;
    end else if (level) begin
      if (high_end) begin
        level     <= 1'b0;
        phase_cnt <= '0;
      end else begin
        phase_cnt <= phase_cnt + 1'b1;
      end
    end else begin
      if (low_end) begin
        level     <= 1'b1;
        phase_cnt <= '0;
      end else begin
        phase_cnt <= phase_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irtx_interval_timer.sv
module irtx_interval_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fast_step,
  input  logic             period_tick,
  input  logic [IVL_W-1:0] reload,
  input  logic             data_in,
  output logic             data_lat,
  output logic             done
);
  logic [IVL_W-1:0] remain;
  logic             primed;
  logic             step;
  logic             at_zero;

  assign step    = fast_step ? 1'b1 : period_tick;
  assign at_zero = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      remain   <= '0;
      primed   <= 1'b0;
      data_lat <= 1'b0;
      done     <= 1'b0;
    end else if (!primed) begin
      primed   <= 1'b1;
      remain   <= reload;
      data_lat <= data_in;
      done     <= 1'b0;
    end else begin
      done <= step && at_zero;
      if (step) begin
        if (at_zero) begin
          remain   <= reload;
          data_lat <= data_in;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irtx_output_stage.sv
module irtx_output_stage
  import irtx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       pol,
  input  logic [1:0] mode,
  input  logic       carrier,
  input  logic       data_lat,
  output logic       tx_q,
  output logic       env_q
);
  logic tx_next;
  logic env_next;
  logic shaped;

  assign shaped = carrier ^ pol;

  always_comb begin
    if (!run) begin
      tx_next  = pol;
      env_next = 1'b0;
    end else begin
      if (carrier_free(mode)) tx_next = shaped;
      else                    tx_next = data_lat ? shaped : pol;
      env_next = env_pin_on(mode) ? (data_lat ^ pol) : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= 1'b0;
      env_q <= 1'b0;
    end else begin
      tx_q  <= tx_next;
      env_q <= env_next;
    end
  end
endmodule

// File: rtl/ir_tx_modulator.sv
module ir_tx_modulator #(
  parameter int CNT_W = 8,
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             tx_pol,
  input  logic             tx_data,
  input  logic [1:0]       env_mode,
  input  logic             fast_step,
  input  logic [CNT_W-1:0] car_high,
  input  logic [CNT_W-1:0] car_low,
  input  logic [IVL_W-1:0] interval_len,
  output logic             tx_out,
  output logic             env_out,
  output logic             interval_done
);
  logic carrier;
  logic period_tick;
  logic data_lat;

  irtx_carrier_gen #(.CNT_W(CNT_W)) u_carrier (
    .clk         (clk),
    .rst         (rst),
    .run         (enable),
    .high_len    (car_high),
    .low_len     (car_low),
    .carrier     (carrier),
    .period_tick (period_tick)
  );

  irtx_interval_timer #(.IVL_W(IVL_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run         (enable),
    .fast_step   (fast_step),
    .period_tick (period_tick),
    .reload      (interval_len),
    .data_in     (tx_data),
    .data_lat    (data_lat),
    .done        (interval_done)
  );

  irtx_output_stage u_out (
    .clk      (clk),
    .rst      (rst),
    .run      (enable),
    .pol      (tx_pol),
    .mode     (env_mode),
    .carrier  (carrier),
    .data_lat (data_lat),
    .tx_q     (tx_out),
    .env_q    (env_out)
  );
endmodule

// File: rtl/irtx_checker.sv
module irtx_checker (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       tx_pol,
  input logic [1:0] env_mode,
  input logic       tx_out,
  input logic       env_out,
  input logic       interval_done
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!tx_out && !env_out && !interval_done));

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ((tx_out == $past(tx_pol)) && !env_out));

  assert_env_off_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && (env_mode == 2'b00 || env_mode == 2'b11)) |=> !env_out);

  assert_done_needs_run_R10: assert property (@(posedge clk) disable iff (rst)
    interval_done |-> $past(enable));
endmodule

bind ir_tx_modulator irtx_checker u_irtx_checker (
  .clk           (clk),
  .rst           (rst),
  .enable        (enable),
  .tx_pol        (tx_pol),
  .env_mode      (env_mode),
  .tx_out        (tx_out),
  .env_out       (env_out),
  .interval_done (interval_done)
);

// File: tb/test_ir_tx_modulator.sv
`timescale 1ns/1ps
module test_ir_tx_modulator;
  localparam int CW = 4;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          tx_pol = 1'b0;
  logic          tx_data = 1'b0;
  logic [1:0]    env_mode = 2'b00;
  logic          fast_step = 1'b0;
  logic [CW-1:0] car_high = '0;
  logic [CW-1:0] car_low = '0;
  logic [IW-1:0] interval_len = '0;
  logic          tx_out, env_out, interval_done;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ir_tx_modulator #(.CNT_W(CW), .IVL_W(IW)) i_ir_tx_modulator (
    .clk(clk), .rst(rst), .enable(enable), .tx_pol(tx_pol), .tx_data(tx_data),
    .env_mode(env_mode), .fast_step(fast_step), .car_high(car_high),
    .car_low(car_low), .interval_len(interval_len),
    .tx_out(tx_out), .env_out(env_out), .interval_done(interval_done)
  );

  // Behavioural reference: carrier phase (R3), interval (R8, R9, R10), pins (R4-R7, R11)
  int  ref_phase_left;
  bit  ref_high;
  int  ref_steps_left;
  bit  ref_started;
  bit  ref_bit;
  bit  exp_tx, exp_env, exp_done;
  bit  prev_rst, prev_en;

  initial begin
    ref_phase_left = 0; ref_high = 1; ref_steps_left = 0; ref_started = 0;
    ref_bit = 0; exp_tx = 0; exp_env = 0; exp_done = 0; prev_rst = 1; prev_en = 0;
  end

  always @(posedge clk) begin
    bit n_tx, n_env, n_done, period_end, adv, carrier_now;
    prev_rst = rst;
    prev_en  = enable;
    if (rst) begin
      exp_tx = 0; exp_env = 0; exp_done = 0;
      ref_high = 1; ref_phase_left = 0; ref_started = 0; ref_steps_left = 0; ref_bit = 0;
    end else if (!enable) begin
      exp_tx = tx_pol; exp_env = 0; exp_done = 0;
      ref_high = 1; ref_phase_left = 0; ref_started = 0; ref_steps_left = 0; ref_bit = 0;
    end else begin
      carrier_now = ref_high;
      if (env_mode == 2'b10) n_tx = carrier_now ^ tx_pol;
      else                   n_tx = ref_bit ? (carrier_now ^ tx_pol) : tx_pol;
      n_env = (env_mode == 2'b01 || env_mode == 2'b10) ? (ref_bit ^ tx_pol) : 1'b0;
      period_end = !ref_high && (ref_phase_left >= int'(car_low));
      adv = fast_step || period_end;
      n_done = 0;
      if (!ref_started) begin
        ref_started = 1; ref_steps_left = int'(interval_len); ref_bit = tx_data;
      end else if (adv) begin
        if (ref_steps_left == 0) begin
          n_done = 1; ref_steps_left = int'(interval_len); ref_bit = tx_data;
        end else ref_steps_left--;
      end
      if (ref_high) begin
        if (ref_phase_left >= int'(car_high)) begin ref_high = 0; ref_phase_left = 0; end
        else ref_phase_left++;
      end else begin
        if (ref_phase_left >= int'(car_low)) begin ref_high = 1; ref_phase_left = 0; end
        else ref_phase_left++;
      end
      exp_tx = n_tx; exp_env = n_env; exp_done = n_done;
    end
  end

  task automatic check_bit(input string tag, input string what, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    string t_tx, t_env, t_done;
    if (prev_rst) begin
      t_tx = "R1"; t_env = "R1"; t_done = "R1";
    end else if (!prev_en) begin
      t_tx = "R2"; t_env = "R2"; t_done = "R2";
    end else begin
      t_tx   = (env_mode == 2'b10) ? "R5/R11/R3" : "R4/R11/R3";
      t_env  = (env_mode == 2'b01 || env_mode == 2'b10) ? "R7/R11" : "R6";
      t_done = fast_step ? "R8/R10" : "R9/R10";
    end
    check_bit(t_tx, "tx_out", tx_out, exp_tx);
    check_bit(t_env, "env_out", env_out, exp_env);
    check_bit(t_done, "interval_done", interval_done, exp_done);
  endtask

  task automatic run_cycles(input int n, input int data_flip_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_now();
      if (($urandom % 100) < data_flip_pct) tx_data = ~tx_data;
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    run_cycles(3, 0);               // R1: reset state
    rst = 0;
    run_cycles(4, 0);               // R2: disabled rest level, pol 0
    tx_pol = 1;
    run_cycles(4, 0);               // R2: rest level follows pol
    tx_pol = 0;
    // R3/R4: known carrier 2 high, 3 low, continuous mark, fast step
    car_high = 4'd1; car_low = 4'd2; interval_len = 6'd3; fast_step = 1; tx_data = 1;
    enable = 1;
    run_cycles(40, 0);
    // R8 / R10: zero reload gives back-to-back done pulses
    interval_len = 6'd0;
    run_cycles(20, 30);
    // R9: per-period stepping
    fast_step = 0; interval_len = 6'd2;
    run_cycles(80, 10);
    // R5/R7: free carrier with envelope, polarity 1
    env_mode = 2'b10; tx_pol = 1;
    run_cycles(60, 10);
    // R6: mode 11 keeps envelope off
    env_mode = 2'b11;
    run_cycles(40, 10);
    // R2: drop enable mid-interval, then restart
    enable = 0;
    run_cycles(5, 0);
    enable = 1; env_mode = 2'b01; car_high = 0; car_low = 0;
    run_cycles(40, 20);
    // Randomised sweeps across all settings
    for (int seg = 0; seg < 60; seg++) begin
      @(negedge clk);
      compare_now();
      car_high     = CW'($urandom % 4);
      car_low      = CW'($urandom % 4);
      interval_len = IW'($urandom % 8);
      fast_step    = 1'($urandom);
      env_mode     = 2'($urandom);
      tx_pol       = 1'($urandom);
      if (($urandom % 8) == 0) enable = ~enable;
      else enable = 1;
      run_cycles(40, 15);
    end
    rst = 1;
    run_cycles(3, 0);               // R1 again after activity
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule